// File: doc/BRIEF.md
# SPI Slave with Select-Boundary Tracking

This block is an SPI slave (clock idles low, data captured on the rising clock edge, output changed on the falling edge, most significant bit first) for a controller that runs on its own system clock. The serial clock, the input data line and the active-low chip select are each brought into the system clock domain through a two-flop synchronizer. Received bytes go to local logic as single-cycle strobes. Response bytes are fetched from local logic through a ready/take pair.

The block keeps track of chip-select boundaries for the local logic. The first complete byte after select goes low is marked as a command byte. Every later byte within the same select is marked as a parameter. Because the mark comes from the synchronized select inside the shifting logic, it can never disagree with the byte it belongs to.

The first byte shifted out in every transaction is a status byte built by the hardware. This lets a master drop select at any moment and poll whether the local side has a response waiting and can accept data. If the local logic has no response byte when the shifter needs one, the block sends a fill byte and records a sticky underrun. The system clock must run at least 8 times faster than the serial clock.

Top module: `spi_select_slave`

## Requirements
- R1: While chip select is high, `miso_oe` is 0, and activity on `sclk_in` and `mosi_in` produces no `rx_valid` and no `tx_take`.
- R2: Bits are captured on rising `sclk_in` edges, most significant bit first. After the 8th rising edge of a byte, `rx_valid` pulses for one cycle with the byte on `rx_data`.
- R3: `rx_first` is 1 for the first complete byte after chip select goes low, and 0 for every later byte under the same select.
- R4: The first byte on `miso_out` is the status byte. Bit 7 is `tx_valid`, bit 6 is `rx_ready`, bit 5 is the underrun flag and bits 4..0 are 0. Status bit 7 is on `miso_out` with `miso_oe`=1 once select is low and before the first clock edge.
- R5: `miso_out` changes on falling `sclk_in` edges, most significant bit first. At the falling edge that ends each complete byte, the next byte to send is `tx_data`, taken with a one-cycle `tx_take` pulse, when `tx_valid` is 1.
- R6: If `tx_valid` is 0 at that boundary, the byte 0xFF is sent instead and the underrun flag is set. The flag is reported in the next status byte and cleared when that next select begins.
- R7: If chip select rises partway through a byte, the partial byte is dropped with no `rx_valid`. The next select starts at bit 0, and its first byte is flagged as the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock from the master |
| mosi_in | input | 1 | Serial data from the master |
| csn_in | input | 1 | Active-low chip select |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad driver; 0 means high impedance |
| rx_valid | output | 1 | One-cycle strobe: a byte was received |
| rx_data | output | 8 | Received byte |
| rx_first | output | 1 | Received byte is the first since select (command byte) |
| rx_ready | input | 1 | Local logic can accept bytes (reported in status) |
| tx_valid | input | 1 | Local logic has a response byte on tx_data |
| tx_data | input | 8 | Response byte |
| tx_take | output | 1 | One-cycle strobe: tx_data was loaded into the shifter |

## Verification
The bench goes after four corner cases.

- Select raised mid-byte. A design that kept the bit count would misalign every byte of the following transaction and mislabel its command byte.
- Transactions with no response ready. A slave that does not track underrun would send stale data, or would leave the status flag clear or never clear it.
- Serial clock and data toggling while deselected. A slave that does not gate on select would emit spurious bytes or consume responses.
- The status bit shown before any clock edge. A slave that loads its first byte late would present a wrong first bit.

Random byte counts, data values and ready levels are mixed with these directed cases.

// File: rtl/spi_select_slave.sv
module spi_select_slave #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  FILL_BYTE   = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_in,
  input  logic       mosi_in,
  input  logic       csn_in,
  output logic       miso_out,
  output logic       miso_oe,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_first,
  input  logic       rx_ready,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_take
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclk_sy, mosi_sy, csn_sy;
  logic         sclk_d, csn_d;
  logic [2:0]   bitcnt;
  logic [7:0]   shift_rx, shift_tx;
  logic         first_pending, underrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      mosi_sy <= '0;
      csn_sy  <= '1;
      sclk_d  <= 1'b0;
      csn_d   <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[TOP-1:0], sclk_in};
      mosi_sy <= {mosi_sy[TOP-1:0], mosi_in};
      csn_sy  <= {csn_sy[TOP-1:0], csn_in};
      sclk_d  <= sclk_sy[TOP];
      csn_d   <= csn_sy[TOP];
    end
  end

  wire s_sclk    = sclk_sy[TOP];
  wire s_mosi    = mosi_sy[TOP];
  wire s_csn     = csn_sy[TOP];
  wire sclk_rise = s_sclk & ~sclk_d;
  wire sclk_fall = ~s_sclk & sclk_d;
  wire sel_edge  = ~s_csn & csn_d;
  wire [7:0] status = {tx_valid, rx_ready, underrun, 5'b00000};

  assign miso_oe  = ~csn_in;
  assign miso_out = shift_tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt        <= '0;
      shift_rx      <= '0;
      shift_tx      <= '0;
      first_pending <= 1'b1;
      underrun      <= 1'b0;
      rx_valid      <= 1'b0;
      rx_data       <= '0;
      rx_first      <= 1'b0;
      tx_take       <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_take  <= 1'b0;
      if (sel_edge) underrun <= 1'b0;
      if (s_csn) begin
        bitcnt        <= '0;
        first_pending <= 1'b1;
        shift_tx      <= status;
      end else begin
        if (sclk_rise) begin
          shift_rx <= {shift_rx[6:0], s_mosi};
          bitcnt   <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            rx_valid      <= 1'b1;
            rx_data       <= {shift_rx[6:0], s_mosi};
            rx_first      <= first_pending;
            first_pending <= 1'b0;
          end
        end
        if (sclk_fall) begin
          if (bitcnt == 3'd0) begin
            if (tx_valid) begin
              shift_tx <= tx_data;
              tx_take  <= 1'b1;
            end else begin
              shift_tx <= FILL_BYTE;
              underrun <= 1'b1;
            end
          end else begin
            shift_tx <= {shift_tx[6:0], 1'b1};
          end
        end
      end
    end
  end

  logic chk_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chk_seen <= 1'b0;
    else if (s_csn)    chk_seen <= 1'b0;
    else if (rx_valid) chk_seen <= 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || tx_take) |-> $past(!s_csn));

  assert_rx_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_cmd_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_first == !chk_seen));

  assert_take_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !tx_take);

  assert_underrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(!tx_valid && !s_csn));

  assert_abort_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_csn) |=> (!rx_valid && bitcnt == 3'd0));

endmodule

// File: tb/spi_select_slave_tb.sv
module spi_select_slave_tb;
  localparam int HALF = 6;
  localparam int WD   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk_in = 1'b0, mosi_in = 1'b0, csn_in = 1'b1;
  logic rx_ready = 1'b0, tx_valid = 1'b0;
  logic [7:0] tx_data;
  logic miso_out, miso_oe, rx_valid, rx_first, tx_take;
  logic [7:0] rx_data;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  int rx_cnt = 0, take_cnt = 0, rx_base = 0, take_base = 0;
  logic [7:0] tb_bytes [0:7];
  logic [7:0] mo_bytes [0:7];
  logic [7:0] got_miso [0:7];
  logic [7:0] rx_got [0:63];
  logic       rx_fl  [0:63];
  logic       exp_under = 1'b0;

  always #10 clk = ~clk;

  assign tx_data = tb_bytes[3'(take_cnt - take_base)];

  spi_select_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .mosi_in(mosi_in),
    .csn_in(csn_in), .miso_out(miso_out), .miso_oe(miso_oe),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_first(rx_first),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_take(tx_take)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_got[6'(rx_cnt)] = rx_data;
      rx_fl[6'(rx_cnt)]  = rx_first;
      rx_cnt = rx_cnt + 1;
    end
    if (tx_take) take_cnt = take_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_status(input bit tv, input bit rr, input bit ur);
    return {tv, rr, ur, 5'b00000};
  endfunction

  task automatic idle_noise();
    int rb = rx_cnt, tk = take_cnt;
    csn_in = 1'b1;
    for (int i = 0; i < 12; i++) begin
      mosi_in = 1'($urandom);
      sclk_in = ~sclk_in;
      tick(3);
      chk(miso_oe == 1'b0, "R1 oe while deselected", 32'(miso_oe), 0);
    end
    sclk_in = 1'b0;
    tick(6);
    chk(rx_cnt == rb, "R1 no rx while deselected", rx_cnt - rb, 0);
    chk(take_cnt == tk, "R1 no take while deselected", take_cnt - tk, 0);
  endtask

  task automatic run_txn(input int nbytes, input int extra, input bit tv, input bit rr);
    logic [7:0] st;
    int nseg;
    st = exp_status(tv, rr, exp_under);
    for (int i = 0; i < 8; i++) begin
      tb_bytes[i] = 8'($urandom);
      mo_bytes[i] = 8'($urandom);
      got_miso[i] = 8'h00;
    end
    tx_valid  = tv;
    rx_ready  = rr;
    rx_base   = rx_cnt;
    take_base = take_cnt;
    tick(4);
    csn_in = 1'b0;
    tick(HALF);
    chk(miso_oe == 1'b1, "R1 oe when selected", 32'(miso_oe), 1);
    chk(miso_out == st[7], "R4 first status bit before clock", 32'(miso_out), 32'(st[7]));
    nseg = nbytes + ((extra > 0) ? 1 : 0);
    for (int b = 0; b < nseg; b++) begin
      int nb = (b < nbytes) ? 8 : extra;
      for (int k = 0; k < nb; k++) begin
        mosi_in = mo_bytes[b][7-k];
        tick(HALF);
        got_miso[b][7-k] = miso_out;
        sclk_in = 1'b1;
        tick(HALF);
        sclk_in = 1'b0;
      end
    end
    tick(HALF);
    csn_in = 1'b1;
    tick(8);
    chk(rx_cnt - rx_base == nbytes, "R2/R7 received byte count", rx_cnt - rx_base, nbytes);
    for (int b = 0; b < nbytes; b++) begin
      chk(rx_got[6'(rx_base + b)] == mo_bytes[b], "R2 received data", rx_got[6'(rx_base + b)], mo_bytes[b]);
      chk(rx_fl[6'(rx_base + b)] == (b == 0), "R3 command flag", 32'(rx_fl[6'(rx_base + b)]), 32'(b == 0));
      if (b == 0) begin
        chk(got_miso[0] == st, "R4 status byte", got_miso[0], st);
        if (st[5]) chk(got_miso[0][5] == 1'b1, "R6 underrun reported", 32'(got_miso[0][5]), 1);
      end else if (tv)
        chk(got_miso[b] == tb_bytes[b-1], "R5 response byte", got_miso[b], tb_bytes[b-1]);
      else
        chk(got_miso[b] == 8'hFF, "R6 fill byte on underrun", got_miso[b], 8'hFF);
    end
    chk(take_cnt - take_base == (tv ? nbytes : 0), "R5 take count", take_cnt - take_base, tv ? nbytes : 0);
    exp_under = !tv && (nbytes > 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) tb_bytes[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    chk(miso_oe == 1'b0, "R1 reset oe", 32'(miso_oe), 0);
    chk(rx_valid == 1'b0, "R2 reset rx_valid", 32'(rx_valid), 0);
    chk(tx_take == 1'b0, "R5 reset tx_take", 32'(tx_take), 0);

    idle_noise();
    run_txn(1, 0, 1'b1, 1'b1);
    run_txn(3, 0, 1'b1, 1'b0);
    run_txn(3, 0, 1'b0, 1'b1);
    run_txn(2, 0, 1'b1, 1'b1);
    run_txn(1, 0, 1'b1, 1'b0);
    run_txn(1, 3, 1'b1, 1'b1);
    run_txn(2, 0, 1'b1, 1'b1);
    run_txn(0, 5, 1'b0, 1'b0);
    run_txn(2, 0, 1'b1, 1'b1);
    idle_noise();

    for (int t = 0; t < 40; t++) begin
      int nb = $urandom_range(0, 4);
      int ex = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      if (nb == 0 && ex == 0) nb = 1;
      run_txn(nb, ex, 1'($urandom), 1'($urandom));
      if (t % 5 == 4) idle_noise();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule